// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Pending Latch

This block collects level-sensitive interrupt sources arranged in groups (nine groups of 32 lines by default) and drives one interrupt output per group. Each group owns two 32-bit registers on a single-cycle memory-mapped port: a control word and a status word. Firmware enables lines through the control word. Once enables stop growing, writes to the control word mask and unmask the group. Firmware reads the status word to learn which sources fired, and writes ones to it to retire them.

A source event in a group is the rising edge of the OR of that group's lines. The event captures the enabled active lines. The captured set goes straight into status, and the output rises, only when the group is unmasked and its status is empty. In any other case it is added to a pending word. When firmware drains status with an ordinary acknowledge, any pending set is moved into status as a new batch. If nothing is pending, the output falls.

Each group runs a two-state machine: `G_QUIET` (output low) and `G_ACTIVE` (output high). The transitions are DELIVER (`G_QUIET`→`G_ACTIVE`, a captured set or pending set loaded into status), RELOAD (`G_ACTIVE`→`G_ACTIVE`, a new batch loaded while already high) and RETIRE (`G_ACTIVE`→`G_QUIET`, status drained with nothing pending). Every other cycle holds the state.

Top module: `irq_batch_agg`

## Requirements
- R1: Address bits [11:8] select the group and bits [7:0] select the register: 0x00 is the control word and 0x04 is the status word. A read returns the stored word combinationally. Any other offset reads as zero and ignores writes.
- R2: A group index of 9 or above (NUM_GROUPS or above) reads as zero, and writes to it change no group.
- R3: A source event is a rising edge of the OR of a group's lines, compared against its value one clock earlier. The captured set is the lines ANDed with the group's enable word. A zero captured set has no effect.
- R4: If the mask word is nonzero or status is nonzero, the captured set is ORed into pending and status stays unchanged. Otherwise status takes the captured set and the output is high after that clock edge.
- R5: A control write of zero while the enable word is zero only stores zero in the control word.
- R6: A control write that adds bits to the sticky enable word (enable |= data) stores the data and leaves the mask word unchanged.
- R7: A control write that adds no enable bits computes change = stored ^ data. If change & data is nonzero, the change bits are cleared from the mask word. Otherwise they are set in it. The data is stored in both cases.
- R8: A status write clears the bits written as one. A write of 0xFFFFFFFF only clears, and the output keeps its level.
- R9: A status write other than all-ones that leaves status zero moves a nonzero pending word into status, clears pending and drives the output high. With pending zero it drives the output low. The output only falls on such a write.
- R10: Reset clears every control, status, enable, mask and pending word and every output.
- R11: When a register write and a source event reach the same group in one cycle, the write is applied first. The event is then judged against the updated enable, mask and status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_GROUPS*LINES | Source lines, group g in bits [g*LINES +: LINES] |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | NUM_GROUPS | One interrupt output per group |

## Verification
The hardest case to reach is a pending set that drains while the group is quiet. Getting there takes a masking toggle on the control word, then a source edge that goes to pending while status is empty, then an unmask, and finally a status write of zero. That write clears nothing yet must still fire DELIVER. The bench walks through this sequence and also drives a status acknowledge and a new source edge in the same cycle, which exercises the write-first ordering. Each step is followed by read-backs of the control and status words and a check of the output vector.

// File: rtl/irq_batch_pkg.sv
package irq_batch_pkg;
    typedef enum logic {
        G_QUIET  = 1'b0,
        G_ACTIVE = 1'b1
    } grp_state_e;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_STATUS = 8'h04;
    localparam int         GRP_LSB    = 8;
    localparam int         GRP_W      = 4;
endpackage

// File: rtl/irq_batch_decode.sv
module irq_batch_decode
    import irq_batch_pkg::*;
#(
    parameter int NUM_GROUPS = 9,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 12
) (
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_we,
    input  logic [NUM_GROUPS*DATA_W-1:0] ctrl_flat,
    input  logic [NUM_GROUPS*DATA_W-1:0] st_flat,
    output logic [NUM_GROUPS-1:0]        ctrl_wr,
    output logic [NUM_GROUPS-1:0]        st_wr,
    output logic [DATA_W-1:0]            bus_rdata
);
    logic [GRP_W-1:0] grp;
    logic [7:0]       ofs;

    assign grp = bus_addr[GRP_LSB +: GRP_W];
    assign ofs = bus_addr[7:0];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_sel
        logic hit;
        assign hit        = (int'(grp) == g);
        assign ctrl_wr[g] = bus_we && hit && (ofs == OFS_CTRL);
        assign st_wr[g]   = bus_we && hit && (ofs == OFS_STATUS);
    end

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (int'(grp) == g) begin
                if (ofs == OFS_CTRL)   bus_rdata = ctrl_flat[g*DATA_W +: DATA_W];
                if (ofs == OFS_STATUS) bus_rdata = st_flat[g*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/irq_batch_group.sv
module irq_batch_group
    import irq_batch_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines,
    input  logic             ctrl_wr,
    input  logic             st_wr,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] ctrl_q,
    output logic [LINES-1:0] st_q,
    output logic             irq
);
    grp_state_e       state_q, state_n;
    logic [LINES-1:0] en_q, en_n, mask_q, mask_n, pend_q, pend_n;
    logic [LINES-1:0] ctrl_n, st_n, chg, cap;
    logic             any_q, evt, deliver, retire;

    assign evt = (|lines) && !any_q;

    always_comb begin
        en_n    = en_q;
        mask_n  = mask_q;
        ctrl_n  = ctrl_q;
        st_n    = st_q;
        pend_n  = pend_q;
        deliver = 1'b0;
        retire  = 1'b0;
        chg     = ctrl_q ^ wdata;
        cap     = '0;

        if (ctrl_wr) begin
            if (wdata == '0 && en_q == '0) begin
                ctrl_n = wdata;
            end else begin
                en_n   = en_q | wdata;
                ctrl_n = wdata;
                if (en_n == en_q) begin
                    if ((chg & wdata) != '0) mask_n = mask_q & ~chg;
                    else                     mask_n = mask_q | chg;
                end
            end
        end

        if (st_wr) begin
            st_n = st_q & ~wdata;
            if (wdata != '1 && st_n == '0) begin
                if (pend_q != '0) begin
                    st_n    = pend_q;
                    pend_n  = '0;
                    deliver = 1'b1;
                end else begin
                    retire = 1'b1;
                end
            end
        end

        cap = lines & en_n;
        if (evt && cap != '0) begin
            if (mask_n != '0 || st_n != '0) begin
                pend_n = pend_n | cap;
            end else begin
                st_n    = cap;
                deliver = 1'b1;
            end
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            G_QUIET:  if (deliver) state_n = G_ACTIVE;
            G_ACTIVE: if (!deliver && retire) state_n = G_QUIET;
            default:  state_n = G_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= G_QUIET;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
            pend_q <= '0;
            ctrl_q <= '0;
            st_q   <= '0;
            any_q  <= 1'b0;
        end else begin
            en_q   <= en_n;
            mask_q <= mask_n;
            pend_q <= pend_n;
            ctrl_q <= ctrl_n;
            st_q   <= st_n;
            any_q  <= |lines;
        end
    end

    assign irq = (state_q == G_ACTIVE);
endmodule

// File: rtl/irq_batch_agg.sv
module irq_batch_agg
    import irq_batch_pkg::*;
#(
    parameter int NUM_GROUPS = 9,
    parameter int LINES      = 32,
    parameter int ADDR_W     = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*LINES-1:0] src_i,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [LINES-1:0]            bus_wdata,
    output logic [LINES-1:0]            bus_rdata,
    output logic [NUM_GROUPS-1:0]       irq_o
);
    localparam int FLAT_W = NUM_GROUPS * LINES;

    logic [FLAT_W-1:0]     ctrl_flat, st_flat;
    logic [NUM_GROUPS-1:0] ctrl_wr, st_wr;

    irq_batch_decode #(
        .NUM_GROUPS(NUM_GROUPS),
        .DATA_W    (LINES),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .ctrl_flat(ctrl_flat),
        .st_flat  (st_flat),
        .ctrl_wr  (ctrl_wr),
        .st_wr    (st_wr),
        .bus_rdata(bus_rdata)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        irq_batch_group #(.LINES(LINES)) u_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .lines  (src_i[g*LINES +: LINES]),
            .ctrl_wr(ctrl_wr[g]),
            .st_wr  (st_wr[g]),
            .wdata  (bus_wdata),
            .ctrl_q (ctrl_flat[g*LINES +: LINES]),
            .st_q   (st_flat[g*LINES +: LINES]),
            .irq    (irq_o[g])
        );
    end
endmodule

// File: rtl/irq_batch_chk.sv
module irq_batch_chk #(
    parameter int NUM_GROUPS = 9,
    parameter int LINES      = 32,
    parameter int ADDR_W     = 12
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_we,
    input logic [LINES-1:0]            bus_wdata,
    input logic [LINES-1:0]            bus_rdata,
    input logic [NUM_GROUPS-1:0]       irq_o,
    input logic [NUM_GROUPS*LINES-1:0] st_flat
);
    a_r2_high_group_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr[11:8]) >= NUM_GROUPS) |-> (bus_rdata == '0));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        logic st_hit;
        assign st_hit = bus_we && (int'(bus_addr[11:8]) == g) && (bus_addr[7:0] == 8'h04);

        a_r8_init_clear_holds_irq: assert property (@(posedge clk) disable iff (!rst_n)
            (st_hit && bus_wdata == '1 && irq_o[g]) |=> irq_o[g]);

        a_r4_rise_loads_status: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[g]) |-> (st_flat[g*LINES +: LINES] != '0));

        a_r9_fall_empty_status: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_o[g]) |-> (st_flat[g*LINES +: LINES] == '0));

        a_r9_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o[g] && !st_hit) |=> irq_o[g]);
    end
endmodule

bind irq_batch_agg irq_batch_chk #(
    .NUM_GROUPS(NUM_GROUPS),
    .LINES     (LINES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o),
    .st_flat  (st_flat)
);

// File: tb/test_irq_batch_agg.sv
module test_irq_batch_agg;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 9;
    localparam int LN = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NG*LN-1:0]  src_i = '0;
    logic [11:0]       bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [LN-1:0]     bus_wdata = '0;
    logic [LN-1:0]     bus_rdata;
    logic [NG-1:0]     irq_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_batch_agg #(.NUM_GROUPS(NG), .LINES(LN), .ADDR_W(12)) i_irq_batch_agg (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // monitor: compares queued expectations a quarter period after the falling edge
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {{(32-NG){1'b0}}, irq_o} : bus_rdata;
            compared++;
            if (act !== it.exp) begin
                mismatched++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_we = 1'b0;
        bus_addr = a;
        sb_q.push_back('{1'b0, e, tag});
    endtask

    task automatic chk_irq(input logic [NG-1:0] e, input string tag);
        @(negedge clk);
        bus_we = 1'b0;
        sb_q.push_back('{1'b1, {{(32-NG){1'b0}}, e}, tag});
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic lines(input int g, input logic [31:0] v);
        @(negedge clk);
        src_i[g*LN +: LN] = v;
    endtask

    task automatic wr_and_lines(input logic [11:0] a, input logic [31:0] d,
                                input int g, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        src_i[g*LN +: LN] = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse(input int g, input logic [31:0] v);
        lines(g, '0);
        lines(g, v);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk_read(12'h000, 32'h0, "R10 ctrl0 after reset");
        chk_read(12'h004, 32'h0, "R10 status0 after reset");
        chk_irq(9'h000, "R10 irq after reset");

        // R6 enable accumulation, R1 read-back
        wr(12'h000, 32'h0000_000F);
        chk_read(12'h000, 32'h0000_000F, "R1 R6 ctrl0 stored");

        // R3 R4 capture & deliver
        pulse(0, 32'h0000_0013);
        chk_read(12'h004, 32'h0000_0003, "R3 status0 masked by enable");
        chk_irq(9'h001, "R4 irq0 high");

        // R4 defer into pending while status busy
        pulse(0, 32'h0000_0004);
        chk_read(12'h004, 32'h0000_0003, "R4 status0 unchanged while busy");

        // R8 partial clear
        wr(12'h004, 32'h0000_0001);
        chk_read(12'h004, 32'h0000_0002, "R8 status0 partial clear");
        chk_irq(9'h001, "R8 irq0 still high");

        // R9 drain with pending -> reload
        wr(12'h004, 32'h0000_0002);
        chk_read(12'h004, 32'h0000_0004, "R9 pending moved to status0");
        chk_irq(9'h001, "R9 irq0 reasserted");

        // R9 drain with nothing pending -> low
        wr(12'h004, 32'h0000_0004);
        chk_read(12'h004, 32'h0, "R9 status0 empty");
        chk_irq(9'h000, "R9 irq0 low");

        // R3 line not enabled has no effect
        pulse(0, 32'h0000_0010);
        chk_read(12'h004, 32'h0, "R3 disabled line ignored");
        chk_irq(9'h000, "R3 irq0 stays low");

        // R7 mask: change=1, change&data=0 -> mask bit0
        wr(12'h000, 32'h0000_000E);
        chk_read(12'h000, 32'h0000_000E, "R7 ctrl0 stored after mask");
        pulse(0, 32'h0000_0002);
        chk_read(12'h004, 32'h0, "R4 masked group defers");
        chk_irq(9'h000, "R4 masked irq0 low");

        // R7 unmask, then zero status write drains pending from quiet
        wr(12'h000, 32'h0000_000F);
        chk_irq(9'h000, "R7 unmask alone keeps irq0 low");
        wr(12'h004, 32'h0000_0000);
        chk_read(12'h004, 32'h0000_0002, "R9 zero write drains pending");
        chk_irq(9'h001, "R9 irq0 high after drain");

        // R8 all-ones initialisation clear
        wr(12'h004, 32'hFFFF_FFFF);
        chk_read(12'h004, 32'h0, "R8 status0 cleared by all-ones");
        chk_irq(9'h001, "R8 irq0 held by all-ones");
        wr(12'h004, 32'h0000_0000);
        chk_irq(9'h000, "R9 irq0 low after plain drain");

        // R5 zero write with empty enables
        wr(12'h100, 32'h0);
        chk_read(12'h100, 32'h0, "R5 ctrl1 zero stored");
        pulse(1, 32'h0000_0001);
        chk_irq(9'h000, "R5 group1 nothing enabled");

        // R2 out-of-range groups
        wr(12'h900, 32'h0000_00FF);
        wr(12'hF04, 32'h0);
        chk_read(12'h900, 32'h0, "R2 group9 reads zero");
        chk_read(12'h800, 32'h0, "R2 group8 ctrl untouched");
        chk_irq(9'h000, "R2 no irq change");

        // R1 unused offset
        wr(12'h008, 32'h1234_5678);
        chk_read(12'h008, 32'h0, "R1 unused offset reads zero");
        chk_read(12'h000, 32'h0000_000F, "R1 ctrl0 unaffected by unused offset");

        // R11 write-first ordering in group 2
        wr(12'h200, 32'h0000_0003);
        pulse(2, 32'h0000_0001);
        chk_read(12'h204, 32'h0000_0001, "R11 setup status2");
        lines(2, 32'h0);
        wr_and_lines(12'h204, 32'h0000_0001, 2, 32'h0000_0002);
        chk_read(12'h204, 32'h0000_0002, "R11 event after clear delivers");
        chk_irq(9'h004, "R11 irq2 stays high");

        // R6 enable growth keeps mask unchanged
        wr(12'h200, 32'h0000_0004);
        chk_read(12'h200, 32'h0000_0004, "R6 ctrl2 stored on growth");
        wr(12'h204, 32'h0000_0002);
        chk_irq(9'h000, "R9 irq2 low");
        pulse(2, 32'h0000_0004);
        chk_read(12'h204, 32'h0000_0004, "R6 new enable delivers unmasked");
        chk_irq(9'h004, "R6 irq2 high");

        // R10 reset in the middle
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_irq(9'h000, "R10 irq cleared by reset");
        chk_read(12'h204, 32'h0, "R10 status2 cleared by reset");
        chk_read(12'h200, 32'h0, "R10 ctrl2 cleared by reset");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule